// File: doc/BRIEF.md
# Variable-Length Frame Video-Link Transmitter

This block sends one compressed image at a time onto a parallel video link. The image is a run of bytes (metadata first, then payload) and its length changes from image to image. The bytes come from an upstream source with valid/ready handshaking, and that source may pause at any point. The block packs the bytes in pairs into 16-bit words, one byte on each 8-bit tap. It marks every clock that carries a real word with a data qualifier. It keeps a frame qualifier and a line qualifier high around the whole image.

There are no fixed line lengths. The line qualifier does not toggle once per line. It stays high from the opening of the frame to its close, and it follows the frame qualifier clock for clock. A frame opens when the first byte is accepted. It closes after the byte that the source flags as last. If the frame holds an odd number of bytes, the final word is padded with a zero upper tap and flagged with a one-clock tail marker. Between frames the block lowers its ready output, so the frame qualifier stays low for a guaranteed idle gap.

Top module: `vlink_tx`

## Requirements
- R1: While reset is high and in the first clock after it is released, `fval`, `lval`, `dval` and `odd_tail` are 0, `pix` is 0x0000 and `s_ready` is 1.
- R2: `lval` equals `fval` on every clock, so the line qualifier never drops inside a frame.
- R3: `fval` rises in the clock after the first byte of a frame is accepted. No word is marked valid in that clock. With a source that does not pause, the first valid word appears exactly one clock after `fval` rises.
- R4: Bytes are paired in arrival order. The earlier byte of a pair appears on `pix[7:0]` and the later byte on `pix[15:8]`. `dval` is high for exactly one clock per word, in the clock after the byte that completes the word is accepted.
- R5: `dval` is low on every clock that does not carry a newly completed word. If the source pauses between the two bytes of a pair, the held first byte is kept and is paired with the next accepted byte.
- R6: When a frame has an odd byte count, its final word carries the last byte on `pix[7:0]` and 0x00 on `pix[15:8]`. `odd_tail` is high for that one clock only. `odd_tail` is never high on any other word.
- R7: `fval` stays high for exactly one clock after the final valid word, with `dval` low, and is low on the clock after that.
- R8: From the clock after the last byte is accepted until the block is idle again, `s_ready` is 0. The frame qualifier stays low for GAP_CLKS + 1 clocks (3 with the default GAP_CLKS = 2) before the next frame's `fval` can rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Upstream byte is valid |
| s_ready | output | 1 | Block can accept a byte this clock |
| s_data | input | 8 | Upstream byte |
| s_last | input | 1 | Byte is the last of its frame |
| fval | output | 1 | Frame qualifier |
| lval | output | 1 | Line qualifier, high for the whole frame |
| dval | output | 1 | Word on `pix` is valid this clock |
| pix | output | 16 | Two 8-bit taps: tap 0 in bits 7:0, tap 1 in bits 15:8 |
| odd_tail | output | 1 | Final word carries a padded upper tap |

## Verification
The tests drive the main function with four input patterns:
- A one-byte frame, stepped clock by clock. It separates the pad path for a held byte from the normal pairing path and fixes the position of every qualifier edge.
- An even burst with no pauses. It shows the byte order within each word and the exact spacing between `fval` rising and the first word.
- An odd frame with pauses, including a pause between the two bytes of a pair. It shows that pauses add no extra valid clocks, that the half-filled word survives, and that padding comes from the incoming byte.
- Two frames sent back to back with `s_valid` held high. This measures the idle gap that the closed ready output enforces.

// File: rtl/vlink_pkg.sv
package vlink_pkg;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned WORD_W = 2 * LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_PAD,
        ST_CLOSE,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic store;
        logic pair;
        logic pad_in;
        logic pad_held;
    } tap_cmd_t;

    typedef struct packed {
        logic [LANE_W-1:0] hi;
        logic [LANE_W-1:0] lo;
    } tap_word_t;

    function automatic tap_word_t join_taps(input logic [LANE_W-1:0] lo,
                                            input logic [LANE_W-1:0] hi);
        tap_word_t w;
        w.lo = lo;
        w.hi = hi;
        return w;
    endfunction

endpackage

// File: rtl/vlink_pair.sv
module vlink_pair
    import vlink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] byte_in,
    input  tap_cmd_t          cmd,
    output logic              half,
    output tap_word_t         word_q,
    output logic              word_vld,
    output logic              word_pad
);

    localparam logic [LANE_W-1:0] PAD_BYTE = '0;

    logic [LANE_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            half     <= 1'b0;
            word_q   <= '0;
            word_vld <= 1'b0;
            word_pad <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            word_pad <= 1'b0;
            if (cmd.store) begin
                held_q <= byte_in;
                half   <= 1'b1;
            end else if (cmd.pair) begin
                word_q   <= join_taps(held_q, byte_in);
                word_vld <= 1'b1;
                half     <= 1'b0;
            end else if (cmd.pad_in) begin
                word_q   <= join_taps(byte_in, PAD_BYTE);
                word_vld <= 1'b1;
                word_pad <= 1'b1;
                half     <= 1'b0;
            end else if (cmd.pad_held) begin
                word_q   <= join_taps(held_q, PAD_BYTE);
                word_vld <= 1'b1;
                word_pad <= 1'b1;
                half     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vlink_seq.sv
module vlink_seq
    import vlink_pkg::*;
#(
    parameter int unsigned GAP_CLKS = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     s_valid,
    input  logic     s_last,
    input  logic     half,
    output logic     s_ready,
    output logic     frame_q,
    output tap_cmd_t cmd
);

    localparam int unsigned GAP_CW = (GAP_CLKS < 2) ? 1 : $clog2(GAP_CLKS + 1);
    localparam logic [GAP_CW-1:0] GAP_LOAD = GAP_CW'(GAP_CLKS - 1);

    seq_state_e        state_q, state_d;
    logic [GAP_CW-1:0] gap_q;
    logic              take;

    assign take = s_valid && s_ready;

    always_comb begin
        state_d = state_q;
        s_ready = 1'b0;
        cmd     = '0;
        unique case (state_q)
            ST_IDLE: begin
                s_ready = 1'b1;
                if (take) begin
                    cmd.store = 1'b1;
                    state_d   = s_last ? ST_PAD : ST_FRAME;
                end
            end
            ST_FRAME: begin
                s_ready = 1'b1;
                if (take) begin
                    if (half)        cmd.pair   = 1'b1;
                    else if (s_last) cmd.pad_in = 1'b1;
                    else             cmd.store  = 1'b1;
                    if (s_last) state_d = ST_CLOSE;
                end
            end
            ST_PAD: begin
                cmd.pad_held = 1'b1;
                state_d      = ST_CLOSE;
            end
            ST_CLOSE: state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_GAP;
            ST_GAP: begin
                if (gap_q == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            frame_q <= 1'b0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && take) frame_q <= 1'b1;
            else if (state_q == ST_HOLD)    frame_q <= 1'b0;
            if (state_q == ST_HOLD)                     gap_q <= GAP_LOAD;
            else if (state_q == ST_GAP && gap_q != '0)  gap_q <= gap_q - 1'b1;
        end
    end

endmodule

// File: rtl/vlink_tx.sv
module vlink_tx
    import vlink_pkg::*;
#(
    parameter int unsigned GAP_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [LANE_W-1:0] s_data,
    input  logic              s_last,
    output logic              fval,
    output logic              lval,
    output logic              dval,
    output logic [WORD_W-1:0] pix,
    output logic              odd_tail
);

    tap_cmd_t  cmd;
    tap_word_t word;
    logic      half;
    logic      frame;

    vlink_seq #(.GAP_CLKS(GAP_CLKS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .s_valid (s_valid),
        .s_last  (s_last),
        .half    (half),
        .s_ready (s_ready),
        .frame_q (frame),
        .cmd     (cmd)
    );

    vlink_pair u_pair (
        .clk      (clk),
        .rst      (rst),
        .byte_in  (s_data),
        .cmd      (cmd),
        .half     (half),
        .word_q   (word),
        .word_vld (dval),
        .word_pad (odd_tail)
    );

    assign fval = frame;
    assign lval = frame;
    assign pix  = word;

endmodule

// File: rtl/vlink_tx_chk.sv
module vlink_tx_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_valid,
    input logic        s_ready,
    input logic        fval,
    input logic        dval,
    input logic [15:0] pix,
    input logic        odd_tail
);

    a_r3_no_word_on_open: assert property (@(posedge clk) disable iff (rst)
        $rose(fval) |-> !dval);

    a_r4_word_inside_frame: assert property (@(posedge clk) disable iff (rst)
        dval |-> fval);

    a_r5_pause_no_word: assert property (@(posedge clk) disable iff (rst)
        (fval && s_ready && !s_valid) |=> !dval);

    a_r6_pad_zero: assert property (@(posedge clk) disable iff (rst)
        odd_tail |-> (dval && pix[15:8] == 8'h00));

    a_r6_tail_single: assert property (@(posedge clk) disable iff (rst)
        odd_tail |=> (!odd_tail && !dval));

    a_r7_trail_clock: assert property (@(posedge clk) disable iff (rst)
        $fell(fval) |-> !$past(dval));

    a_r8_gap_closed: assert property (@(posedge clk) disable iff (rst)
        $fell(fval) |-> !s_ready);

    a_r8_gap_min: assert property (@(posedge clk) disable iff (rst)
        $fell(fval) |=> !fval);

endmodule

bind vlink_tx vlink_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .fval     (fval),
    .dval     (dval),
    .pix      (pix),
    .odd_tail (odd_tail)
);

// File: tb/tb_vlink_tx.sv
module tb_vlink_tx;

    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [7:0]  s_data = 8'h00;
    logic        s_last = 1'b0;
    logic        fval, lval, dval, odd_tail;
    logic [15:0] pix;

    int n_checks = 0;
    int n_fail   = 0;

    vlink_tx #(.GAP_CLKS(GAP)) dut (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .fval(fval), .lval(lval),
        .dval(dval), .pix(pix), .odd_tail(odd_tail)
    );

    always #2 clk = ~clk;

    // monitor, sampled away from the active edge
    logic [15:0] mon_w[$];
    logic        mon_o[$];
    int cyc = 0, rise_cyc = 0, fall_cyc = 0, first_dval = 0, last_dval = 0;
    int last_gap = 0, lval_bad = 0;
    logic prev_f = 1'b0, want_first = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (lval !== fval) lval_bad++;
            if (fval && !prev_f) begin
                last_gap   = cyc - fall_cyc;
                rise_cyc   = cyc;
                want_first = 1'b1;
            end
            if (!fval && prev_f) fall_cyc = cyc;
            if (dval) begin
                mon_w.push_back(pix);
                mon_o.push_back(odd_tail);
                last_dval = cyc;
                if (want_first) begin
                    first_dval = cyc;
                    want_first = 1'b0;
                end
            end
            prev_f = fval;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic last);
        s_valid = 1'b1;
        s_data  = b;
        s_last  = last;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pause(input int n);
        s_valid = 1'b0;
        s_last  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        s_valid = 1'b0;
        s_last  = 1'b0;
        while (!(s_ready && !fval)) @(negedge clk);
    endtask

    task automatic compare(input string req, input logic [15:0] exp_w[$], input logic exp_o[$]);
        check(req, "word count", mon_w.size(), exp_w.size());
        for (int i = 0; i < exp_w.size() && i < mon_w.size(); i++) begin
            check(req, "word value", mon_w[i], exp_w[i]);
            check("R6", "odd_tail on word", mon_o[i], exp_o[i]);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "fval in reset", fval, 0);
        check("R1", "dval in reset", dval, 0);
        check("R1", "pix in reset", pix, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "lval after reset", lval, 0);
        check("R1", "odd_tail after reset", odd_tail, 0);
        check("R1", "s_ready after reset", s_ready, 1);
    endtask

    task automatic t_single_byte();
        s_valid = 1'b1; s_data = 8'hA5; s_last = 1'b1;
        check("R8", "ready before accept", s_ready, 1);
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        check("R3", "fval after first byte", fval, 1);
        check("R3", "no word on open clock", dval, 0);
        check("R8", "ready closed after last", s_ready, 0);
        @(negedge clk);
        check("R6", "pad word valid", dval, 1);
        check("R6", "pad word value", pix, 16'h00A5);
        check("R6", "odd_tail with pad", odd_tail, 1);
        @(negedge clk);
        check("R7", "fval held after last word", fval, 1);
        check("R7", "dval low in trail", dval, 0);
        check("R6", "odd_tail one clock", odd_tail, 0);
        @(negedge clk);
        check("R7", "fval low after trail", fval, 0);
        check("R8", "ready low in gap 1", s_ready, 0);
        @(negedge clk);
        check("R8", "ready low in gap 2", s_ready, 0);
        @(negedge clk);
        check("R8", "ready back after gap", s_ready, 1);
    endtask

    task automatic t_even_burst();
        logic [15:0] ew[$];
        logic        eo[$];
        mon_w.delete(); mon_o.delete();
        push(8'h11, 0); push(8'h22, 0); push(8'h33, 0);
        push(8'h44, 0); push(8'h55, 0); push(8'h66, 1);
        wait_done();
        ew = '{16'h2211, 16'h4433, 16'h6655};
        eo = '{1'b0, 1'b0, 1'b0};
        compare("R4", ew, eo);
        check("R3", "first word spacing", first_dval - rise_cyc, 1);
        check("R7", "fall after last word", fall_cyc - last_dval, 2);
    endtask

    task automatic t_odd_paused();
        logic [15:0] ew[$];
        logic        eo[$];
        mon_w.delete(); mon_o.delete();
        push(8'h01, 0); pause(3);          // pause inside a pair
        push(8'h02, 0); pause(2);
        push(8'h03, 0); push(8'h04, 0); pause(4);
        push(8'h05, 1);
        wait_done();
        ew = '{16'h0201, 16'h0403, 16'h0005};
        eo = '{1'b0, 1'b0, 1'b1};
        compare("R5", ew, eo);
        check("R7", "fall after padded word", fall_cyc - last_dval, 2);
    endtask

    task automatic t_back_to_back();
        logic [15:0] ew[$];
        logic        eo[$];
        mon_w.delete(); mon_o.delete();
        push(8'hC1, 0); push(8'hC2, 1);
        push(8'hD1, 0); push(8'hD2, 1);
        wait_done();
        ew = '{16'hC2C1, 16'hD2D1};
        eo = '{1'b0, 1'b0};
        compare("R4", ew, eo);
        check("R8", "idle gap between frames", last_gap, GAP + 1);
        check("R2", "lval mismatches", lval_bad, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single_byte();
        t_even_burst();
        t_odd_paused();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule